// File: doc/BRIEF.md
# Translation-Change Hold-Off Gate

This block keeps a count of the protocol operations in flight that depend on address translations staying fixed. The host must not change a translation while any of them is outstanding. When the host asks to change one, the gate answers with an acknowledge pulse. The pulse comes on the next cycle if nothing is outstanding. Otherwise it is held back until the count drains to zero.

While such a request waits, the gate refuses every new operation that wants hold-off protection. The count can then only fall, so the wait always ends once the running operations finish. Each start request gets a one-cycle accept or refuse pulse. Bad completions are flagged and do not disturb the count.

All outputs are registered. A result shows one clock after the inputs that cause it.

Top module: `xlate_holdoff_gate`

## Requirements
- R1: After reset the count is 0. Accept, refuse, acknowledge, pending and error are all low.
- R2: A start request is accepted when no change is pending or arriving in the same cycle and the count is below its maximum. An accepted start raises accept for exactly one cycle and raises the count by one on the following cycle.
- R3: A completion pulse at a non-zero count lowers the count by one.
- R4: A change request that arrives at count zero gives an acknowledge pulse on the next cycle, and pending never rises.
- R5: A change request at a non-zero count raises pending and withholds the acknowledge. The acknowledge is given on the cycle after the count reaches zero, including when a same-cycle completion brings it there.
- R6: A start request made while pending is high, or in the same cycle as a change request, raises refuse for one cycle and leaves the count unchanged.
- R7: A start request at the maximum count (2^CNT_W - 1) is refused and leaves the count unchanged.
- R8: A completion at count zero, with no accepted start in the same cycle, leaves the count at zero and sets an error flag. The flag stays set until reset.
- R9: An accepted start and a completion in the same cycle leave the count unchanged.
- R10: Pending falls on the same cycle the acknowledge pulse is issued. The acknowledge lasts one cycle, and accept and refuse are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start_req | input | 1 | Pulse: a new hold-off operation wants to begin |
| op_done | input | 1 | Pulse: an outstanding hold-off operation finished |
| xchg_req | input | 1 | Pulse: host requests a translation change |
| op_accept | output | 1 | One-cycle accept of a start request |
| op_reject | output | 1 | One-cycle refusal of a start request |
| xchg_ack | output | 1 | One-cycle acknowledge of the translation change |
| change_pending | output | 1 | A change request is waiting for the count to drain |
| hold_count | output | CNT_W | Number of outstanding hold-off operations |
| underflow_err | output | 1 | Sticky flag: completion seen at count zero |

## Verification
The bench builds the gate with CNT_W = 4, so the count saturates at 15. The full-count refusal and the drain from the top can then be reached in a few dozen cycles. A behavioural model in the bench predicts every output on every clock. Directed sequences cover change requests that arrive at zero, while the count is draining, and in the same cycle as a start or a final completion. They also cover a completion at zero.

// File: rtl/holdoff_pkg.sv
package holdoff_pkg;

  // Next count value given an increment and a decrement qualifier.
  function automatic int unsigned count_step(input int unsigned cur,
                                             input logic inc,
                                             input logic dec);
    int unsigned r;
    r = cur;
    if (inc && !dec) r = cur + 1;
    if (dec && !inc) r = cur - 1;
    return r;
  endfunction

  // Largest value a counter of the given width holds.
  function automatic int unsigned count_max(input int unsigned width);
    return (1 << width) - 1;
  endfunction

endpackage

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             done_req,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt,
  output logic             at_max,
  output logic             dec_ok,
  output logic             err_evt,
  output logic             err_q
);
  import holdoff_pkg::*;

  localparam int unsigned MAXV = count_max(CNT_W);

  logic [CNT_W-1:0] count_d;
  int unsigned      step_v;

  assign at_max  = (32'(count_q) == MAXV);
  // A completion with an accepted start in the same cycle still balances out.
  assign dec_ok  = done_req && ((count_q != '0) || inc);
  assign err_evt = done_req && !dec_ok;

  always_comb begin
    step_v  = count_step(32'(count_q), inc, dec_ok);
    count_d = step_v[CNT_W-1:0];
  end

  assign count_nxt = count_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      if (err_evt) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/holdoff_admit.sv
module holdoff_admit (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic blocked,
  input  logic at_max,
  output logic start_ok,
  output logic accept_q,
  output logic reject_q
);
  logic start_nak;

  assign start_ok  = start_req && !blocked && !at_max;
  assign start_nak = start_req && !start_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      accept_q <= start_ok;
      reject_q <= start_nak;
    end
  end
endmodule

// File: rtl/holdoff_change.sv
module holdoff_change (
  input  logic clk,
  input  logic rst_n,
  input  logic xchg_req,
  input  logic drained_nxt,
  output logic blocked,
  output logic pend_q,
  output logic ack_q
);
  logic live;
  logic release_now;

  // A request merges into any earlier waiting one.
  assign live        = pend_q || xchg_req;
  assign blocked     = live;
  assign release_now = live && drained_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q  <= release_now;
      pend_q <= live && !drained_nxt;
    end
  end
endmodule

// File: rtl/xlate_holdoff_gate.sv
module xlate_holdoff_gate #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start_req,
  input  logic             op_done,
  input  logic             xchg_req,
  output logic             op_accept,
  output logic             op_reject,
  output logic             xchg_ack,
  output logic             change_pending,
  output logic [CNT_W-1:0] hold_count,
  output logic             underflow_err
);
  logic             blocked;
  logic             at_max;
  logic             start_ok;
  logic             dec_ok;
  logic             err_evt;
  logic [CNT_W-1:0] count_nxt;
  logic             drained_nxt;

  assign drained_nxt = (count_nxt == '0);

  holdoff_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (start_ok),
    .done_req  (op_done),
    .count_q   (hold_count),
    .count_nxt (count_nxt),
    .at_max    (at_max),
    .dec_ok    (dec_ok),
    .err_evt   (err_evt),
    .err_q     (underflow_err)
  );

  holdoff_admit u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (op_start_req),
    .blocked   (blocked),
    .at_max    (at_max),
    .start_ok  (start_ok),
    .accept_q  (op_accept),
    .reject_q  (op_reject)
  );

  holdoff_change u_chg (
    .clk         (clk),
    .rst_n       (rst_n),
    .xchg_req    (xchg_req),
    .drained_nxt (drained_nxt),
    .blocked     (blocked),
    .pend_q      (change_pending),
    .ack_q       (xchg_ack)
  );
endmodule

// File: rtl/xlate_holdoff_gate_chk.sv
module xlate_holdoff_gate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_start_req,
  input logic             op_done,
  input logic             xchg_req,
  input logic             op_accept,
  input logic             op_reject,
  input logic             xchg_ack,
  input logic             change_pending,
  input logic [CNT_W-1:0] hold_count,
  input logic             underflow_err
);
  localparam logic [CNT_W-1:0] TOP = '1;

  a_r2_accept_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_req && !op_done && !xchg_req && !change_pending && hold_count != TOP)
    |=> (op_accept && hold_count == $past(hold_count) + 1'b1));

  a_r6_refuse_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_req && (change_pending || xchg_req)) |=> (op_reject && !op_accept));

  a_r7_refuse_full: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start_req && !op_done && hold_count == TOP) |=> (op_reject && hold_count == TOP));

  a_r5_ack_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ack |-> (hold_count == '0));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ack |-> (!change_pending && $past(change_pending || xchg_req)));

  a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_accept, op_reject}));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_start_req && hold_count != '0) |=> (hold_count == $past(hold_count) - 1'b1));
endmodule

bind xlate_holdoff_gate xlate_holdoff_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_start_req   (op_start_req),
  .op_done        (op_done),
  .xchg_req       (xchg_req),
  .op_accept      (op_accept),
  .op_reject      (op_reject),
  .xchg_ack       (xchg_ack),
  .change_pending (change_pending),
  .hold_count     (hold_count),
  .underflow_err  (underflow_err)
);

// File: tb/test_xlate_holdoff_gate.sv
module test_xlate_holdoff_gate;
  localparam int CNT_W = 4;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start_req = 1'b0;
  logic op_done = 1'b0;
  logic xchg_req = 1'b0;
  logic op_accept, op_reject, xchg_ack, change_pending, underflow_err;
  logic [CNT_W-1:0] hold_count;

  int n_checks = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  // Reference model state
  int m_cnt = 0;
  bit m_acc = 0, m_rej = 0, m_ack = 0, m_pend = 0, m_err = 0;

  always #10 clk = ~clk;

  xlate_holdoff_gate #(.CNT_W(CNT_W)) i_xlate_holdoff_gate (
    .clk(clk), .rst_n(rst_n), .op_start_req(op_start_req), .op_done(op_done),
    .xchg_req(xchg_req), .op_accept(op_accept), .op_reject(op_reject),
    .xchg_ack(xchg_ack), .change_pending(change_pending),
    .hold_count(hold_count), .underflow_err(underflow_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: a waiting request refuses starts; acknowledge follows a drained count.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_rej = 0; m_ack = 0; m_pend = 0; m_err = 0;
    end else begin
      bit waiting, took, drop;
      waiting = m_pend || xchg_req;
      took = op_start_req && !waiting && (m_cnt < MAXC);
      drop = op_done && (m_cnt > 0 || took);
      if (op_done && !drop) m_err = 1;
      if (took) m_cnt++;
      if (drop) m_cnt--;
      m_acc = took;
      m_rej = op_start_req && !took;
      m_ack = waiting && (m_cnt == 0);
      m_pend = waiting && (m_cnt != 0);
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R9 count", int'(hold_count), m_cnt);
      check("R2 accept", int'(op_accept), int'(m_acc));
      check("R6 refuse", int'(op_reject), int'(m_rej));
      check("R5 ack", int'(xchg_ack), int'(m_ack));
      check("R10 pending", int'(change_pending), int'(m_pend));
      check("R8 error", int'(underflow_err), int'(m_err));
    end
  end

  // Drive one cycle of inputs; return 1 ns after the edge that samples them.
  task automatic step(input bit s, input bit d, input bit x);
    @(negedge clk);
    op_start_req = s; op_done = d; xchg_req = x;
    @(posedge clk);
    #1;
    op_start_req = 0; op_done = 0; xchg_req = 0;
  endtask

  initial begin : watchdog
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 count", int'(hold_count), 0);
    check("R1 outputs", int'({op_accept, op_reject, xchg_ack, change_pending, underflow_err}), 0);
    @(negedge clk); rst_n = 1'b1;
    model_on = 1'b1;

    // R2 starts
    step(1, 0, 0);
    check("R2 accept pulse", int'(op_accept), 1);
    check("R2 count", int'(hold_count), 1);
    step(1, 0, 0); step(1, 0, 0);
    check("R2 count three", int'(hold_count), 3);
    // R3 completion
    step(0, 1, 0);
    check("R3 count", int'(hold_count), 2);
    // R9 same-cycle start and completion
    step(1, 1, 0);
    check("R9 balanced", int'(hold_count), 2);

    // R5 change while busy
    step(0, 0, 1);
    check("R5 pending", int'(change_pending), 1);
    check("R5 no ack", int'(xchg_ack), 0);
    step(1, 0, 0);
    check("R6 refuse", int'(op_reject), 1);
    check("R6 count held", int'(hold_count), 2);
    step(0, 1, 0);
    check("R5 still waiting", int'(xchg_ack), 0);
    step(0, 1, 0);
    check("R5 ack on drain", int'(xchg_ack), 1);
    check("R10 pending cleared", int'(change_pending), 0);
    step(0, 0, 0);
    check("R10 ack one cycle", int'(xchg_ack), 0);

    // R4 change at zero
    step(0, 0, 1);
    check("R4 ack", int'(xchg_ack), 1);
    check("R4 no pending", int'(change_pending), 0);
    // R6 start in same cycle as request
    step(1, 0, 1);
    check("R6 same-cycle refuse", int'(op_reject), 1);
    check("R6 count zero", int'(hold_count), 0);

    // R5 change and final completion in same cycle
    step(1, 0, 0);
    step(0, 1, 1);
    check("R5 same-cycle drain ack", int'(xchg_ack), 1);
    check("R5 no pending", int'(change_pending), 0);

    // R7 fill to maximum
    for (int i = 0; i < MAXC; i++) step(1, 0, 0);
    check("R7 full", int'(hold_count), MAXC);
    step(1, 0, 0);
    check("R7 refuse at full", int'(op_reject), 1);
    check("R7 count held", int'(hold_count), MAXC);
    step(1, 1, 0);
    check("R9 full balanced", int'(hold_count), MAXC - 1);
    // drain with a pending change
    step(0, 0, 1);
    for (int i = 0; i < MAXC - 1; i++) step(0, 1, 0);
    check("R5 drained ack", int'(xchg_ack), 1);

    // R8 completion at zero
    step(0, 1, 0);
    check("R8 count stays", int'(hold_count), 0);
    check("R8 flag", int'(underflow_err), 1);
    step(1, 0, 0);
    check("R8 sticky", int'(underflow_err), 1);
    step(0, 1, 0);
    repeat (2) step(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule